// File: doc/BRIEF.md
# Dual framebuffer DMA address sequencer

This block generates the burst read requests that fetch pixel data from display memory for a raster engine. Software programs up to two memory regions, each a base address and an inclusive last-byte address, plus a control word with the buffer mode, the burst length code and a FIFO threshold. Once the raster enable is set, the sequencer walks the active region in bursts of whole 32-bit words. At the region's end it moves to the other region, or returns to the start of region 0 in single-buffer mode. A one-cycle end pulse for the finished region tells software that it may reload that region while the other one is being read.

Requests use a plain valid/acknowledge pair toward memory. The pixel path reports its free FIFO space in words, which gates new requests. It also reports when the FIFO runs empty, which produces an underflow pulse. Base and last-byte values are copied into working registers when a region starts, so a write during a region's scan only takes effect the next time that region begins.

Top module: `dual_fb_dma_seq`

## Requirements
- R1: After reset, req_valid_o, eof0_o, eof1_o and underflow_o are 0, and fifo_thresh_o is 0.
- R2: With control bit 0 clear, only region 0 is read, and it restarts at its base after each end.
- R3: With control bit 0 set, reading starts in region 0 and alternates 0, 1, 0, 1 at each region end.
- R4: Control bits [6:4] hold the burst code: codes 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16 words per burst. Codes 5 to 7 act as 16 words. req_len_o is always 1 to 16.
- R5: Within a region, each burst address is the previous one plus req_len_o×4. The last burst is shortened to the words left, so no address past the inclusive ceiling (base + size − 1) is issued.
- R6: Acceptance of a region's last burst produces a one-cycle pulse on eof0_o for region 0 or on eof1_o for region 1, in the cycle after the accepting edge. The two pulses never occur together.
- R7: Writes to a region's base or ceiling while that region is being read do not change its remaining bursts. They apply the next time that region starts.
- R8: A new request is raised only while raster_en_i is 1 and fifo_free_i is at least the burst word count.
- R9: A raised request keeps its address and length until req_ack_i is seen, as long as raster_en_i stays 1.
- R10: A rising fifo_empty_i while the sequencer is active gives a one-cycle underflow_o pulse. A rise while raster_en_i is 0 gives none.
- R11: Control bits [10:8] appear on fifo_thresh_o from the cycle after the write.
- R12: Clearing raster_en_i withdraws any pending request on the next edge. The next enable restarts at region 0's base.
- R13: Register select codes: 0 control, 1 base 0, 2 ceiling 0, 3 base 1, 4 ceiling 1. A write takes place on an edge with reg_we_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | ADDR_W | Register write data |
| raster_en_i | input | 1 | Raster enable |
| fifo_free_i | input | FREE_W | Free words in the pixel FIFO |
| fifo_empty_i | input | 1 | Pixel FIFO empty |
| req_ack_i | input | 1 | Memory accepts the pending burst |
| req_valid_o | output | 1 | Burst request pending |
| req_addr_o | output | ADDR_W | Burst byte address |
| req_len_o | output | 5 | Burst length in words |
| eof0_o | output | 1 | Region 0 finished |
| eof1_o | output | 1 | Region 1 finished |
| underflow_o | output | 1 | FIFO ran empty while active |
| fifo_thresh_o | output | 3 | FIFO-ready threshold field |

## Verification
The bench walks regions whose sizes are not multiples of the burst: one leaves a single trailing word, and one is a single word. A design that trims the last burst wrongly either reads past the ceiling or loops on a zero-length burst. Other runs use burst code 7, rewrite a region's bounds mid-scan, and drop the enable with a request outstanding. These catch a missing clamp, shadow values leaking into the current scan, and a restart that resumes mid-region instead of at base 0. The FIFO gate is tested one word short of a burst, and the underflow detector is tested with empty held high and with the raster off. A level-sensitive or ungated detector would pulse repeatedly or spuriously.

// File: rtl/fbseq_pkg.sv
package fbseq_pkg;
  localparam int CODE_W   = 3;
  localparam int MAX_CODE = 4;
  localparam int LEN_W    = MAX_CODE + 1;
  localparam int THR_W    = 3;
  localparam int NUM_BUF  = 2;
  localparam int SEL_W    = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_BASE0 = 3'd1,
    SEL_CEIL0 = 3'd2,
    SEL_BASE1 = 3'd3,
    SEL_CEIL1 = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [THR_W-1:0]  thresh;
    logic [CODE_W-1:0] code;
    logic              dual;
  } ctrl_t;

  function automatic logic [LEN_W-1:0] burst_words(input logic [CODE_W-1:0] code);
    if (code >= CODE_W'(MAX_CODE)) return LEN_W'(1) << MAX_CODE;
    return LEN_W'(1) << code;
  endfunction
endpackage

// File: rtl/fbseq_regs.sv
module fbseq_regs
  import fbseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] base_o [NUM_BUF],
  output logic [ADDR_W-1:0] ceil_o [NUM_BUF]
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i && sel_i == SEL_CTRL) begin
      ctrl_q.dual   <= wdata_i[0];
      ctrl_q.code   <= wdata_i[6:4];
      ctrl_q.thresh <= wdata_i[10:8];
    end
  end
  assign ctrl_o = ctrl_q;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_region
    localparam logic [SEL_W-1:0] BaseSel = SEL_W'(1 + 2 * i);
    localparam logic [SEL_W-1:0] CeilSel = SEL_W'(2 + 2 * i);
    logic [ADDR_W-1:0] base_q, ceil_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        ceil_q <= '0;
      end else if (we_i) begin
        if (sel_i == BaseSel) base_q <= wdata_i;
        if (sel_i == CeilSel) ceil_q <= wdata_i;
      end
    end
    assign base_o[i] = base_q;
    assign ceil_o[i] = ceil_q;
  end
endmodule

// File: rtl/fbseq_addr_gen.sv
module fbseq_addr_gen
  import fbseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FREE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  ctrl_t              ctrl_i,
  input  logic [ADDR_W-1:0]  base_i [NUM_BUF],
  input  logic [ADDR_W-1:0]  ceil_i [NUM_BUF],
  input  logic [FREE_W-1:0]  fifo_free_i,
  input  logic               ack_i,
  output logic               req_valid_o,
  output logic [ADDR_W-1:0]  req_addr_o,
  output logic [LEN_W-1:0]   req_len_o,
  output logic [NUM_BUF-1:0] eof_o,
  output logic               running_o
);
  logic              running_q, region_q, valid_q, last_q;
  logic [ADDR_W-1:0] cur_addr_q, cur_ceil_q, addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [NUM_BUF-1:0] eof_q;

  logic [LEN_W-1:0]  bw, nxt_len;
  logic [ADDR_W-1:0] rem_words;
  logic              fits, room, nxt_region;

  always_comb begin
    bw         = burst_words(ctrl_i.code);
    rem_words  = (cur_ceil_q - cur_addr_q + ADDR_W'(1)) >> 2;
    fits       = rem_words <= ADDR_W'(bw);
    nxt_len    = fits ? rem_words[LEN_W-1:0] : bw;
    room       = ADDR_W'(fifo_free_i) >= ADDR_W'(bw);
    nxt_region = ctrl_i.dual ? ~region_q : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q  <= 1'b0;
      region_q   <= 1'b0;
      valid_q    <= 1'b0;
      last_q     <= 1'b0;
      cur_addr_q <= '0;
      cur_ceil_q <= '0;
      addr_q     <= '0;
      len_q      <= '0;
      eof_q      <= '0;
    end else begin
      eof_q <= '0;
      if (!en_i) begin
        running_q <= 1'b0;
        valid_q   <= 1'b0;
        region_q  <= 1'b0;
      end else if (!running_q) begin
        // region start: snapshot the programmed bounds
        running_q  <= 1'b1;
        region_q   <= 1'b0;
        cur_addr_q <= base_i[0];
        cur_ceil_q <= ceil_i[0];
      end else if (valid_q) begin
        if (ack_i) begin
          valid_q <= 1'b0;
          if (last_q) begin
            eof_q[region_q] <= 1'b1;
            region_q   <= nxt_region;
            cur_addr_q <= base_i[nxt_region];
            cur_ceil_q <= ceil_i[nxt_region];
          end else begin
            cur_addr_q <= cur_addr_q + (ADDR_W'(len_q) << 2);
          end
        end
      end else if (room) begin
        valid_q <= 1'b1;
        addr_q  <= cur_addr_q;
        len_q   <= nxt_len;
        last_q  <= fits;
      end
    end
  end

  assign req_valid_o = valid_q;
  assign req_addr_o  = addr_q;
  assign req_len_o   = len_q;
  assign eof_o       = eof_q;
  assign running_o   = running_q;
endmodule

// File: rtl/fbseq_ufl_det.sv
module fbseq_ufl_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic empty_i,
  output logic pulse_o
);
  logic empty_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      empty_q <= empty_i;
      pulse_q <= active_i & empty_i & ~empty_q;
    end
  end
  assign pulse_o = pulse_q;
endmodule

// File: rtl/dual_fb_dma_seq.sv
module dual_fb_dma_seq
  import fbseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FREE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic              raster_en_i,
  input  logic [FREE_W-1:0] fifo_free_i,
  input  logic              fifo_empty_i,
  input  logic              req_ack_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              eof0_o,
  output logic              eof1_o,
  output logic              underflow_o,
  output logic [THR_W-1:0]  fifo_thresh_o
);
  ctrl_t              ctrl;
  logic [ADDR_W-1:0]  base [NUM_BUF];
  logic [ADDR_W-1:0]  ceil [NUM_BUF];
  logic [NUM_BUF-1:0] eof;
  logic               running;

  fbseq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl),
    .base_o  (base),
    .ceil_o  (ceil)
  );

  fbseq_addr_gen #(.ADDR_W(ADDR_W), .FREE_W(FREE_W)) u_gen (
    .clk_i, .rst_ni,
    .en_i        (raster_en_i),
    .ctrl_i      (ctrl),
    .base_i      (base),
    .ceil_i      (ceil),
    .fifo_free_i (fifo_free_i),
    .ack_i       (req_ack_i),
    .req_valid_o (req_valid_o),
    .req_addr_o  (req_addr_o),
    .req_len_o   (req_len_o),
    .eof_o       (eof),
    .running_o   (running)
  );

  fbseq_ufl_det u_ufl (
    .clk_i, .rst_ni,
    .active_i (running & raster_en_i),
    .empty_i  (fifo_empty_i),
    .pulse_o  (underflow_o)
  );

  assign eof0_o        = eof[0];
  assign eof1_o        = eof[1];
  assign fifo_thresh_o = ctrl.thresh;
endmodule

// File: rtl/dual_fb_dma_seq_chk.sv
module dual_fb_dma_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int FREE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              raster_en_i,
  input logic [FREE_W-1:0] fifo_free_i,
  input logic              fifo_empty_i,
  input logic              req_ack_i,
  input logic              req_valid_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [4:0]        req_len_o,
  input logic              eof0_o,
  input logic              eof1_o,
  input logic              underflow_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ack_i && raster_en_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_len_o))); // R9

  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_len_o != 5'd0 && req_len_o <= 5'd16)); // R4

  AST_REQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> ($past(raster_en_i) &&
      32'(req_len_o) <= 32'($past(fifo_free_i)))); // R8

  AST_EOF_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof0_o || eof1_o) |-> $past(req_valid_o && req_ack_i)); // R6

  AST_EOF_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eof0_o && eof1_o)); // R6

  AST_DISABLE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raster_en_i |=> !req_valid_o); // R12

  AST_UFL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> $past(fifo_empty_i)); // R10
endmodule

bind dual_fb_dma_seq dual_fb_dma_seq_chk #(.ADDR_W(ADDR_W), .FREE_W(FREE_W)) u_chk (.*);

// File: tb/tb_dual_fb_dma_seq.sv
`timescale 1ns/1ps
module tb_dual_fb_dma_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic        en = 1'b0;
  logic [5:0]  free = '0;
  logic        empty = 1'b0;
  logic        ack = 1'b0;
  logic        valid;
  logic [31:0] addr;
  logic [4:0]  len;
  logic        eof0, eof1, ufl;
  logic [2:0]  thr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dual_fb_dma_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .raster_en_i(en), .fifo_free_i(free), .fifo_empty_i(empty), .req_ack_i(ack),
    .req_valid_o(valid), .req_addr_o(addr), .req_len_o(len),
    .eof0_o(eof0), .eof1_o(eof1), .underflow_o(ufl), .fifo_thresh_o(thr)
  );

  typedef struct packed {
    logic        dual;
    logic [2:0]  code;
    logic [31:0] b0;
    logic [31:0] c0;
    logic [31:0] b1;
    logic [31:0] c1;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 3'd2, 32'h0000_1000, 32'h0000_1027, 32'h0000_2000, 32'h0000_200F},
    '{1'b1, 3'd1, 32'h0000_0100, 32'h0000_010B, 32'h0000_0400, 32'h0000_0407},
    '{1'b1, 3'd4, 32'h0000_0000, 32'h0000_007F, 32'h0000_0800, 32'h0000_080B},
    '{1'b1, 3'd7, 32'h0000_0040, 32'h0000_0083, 32'h0000_1000, 32'h0000_1003},
    '{1'b0, 3'd0, 32'h0000_0010, 32'h0000_0017, 32'h0000_3000, 32'h0000_3003}
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog (R1..R13 run) cycles=%0d expected <100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_word(input logic dual, input logic [2:0] code,
                                            input logic [2:0] th);
    return {21'd0, th, 1'b0, code, 3'd0, dual};
  endfunction

  task automatic take_burst(input logic [31:0] ea, input logic [4:0] el,
                            input logic e0, input logic e1, input string tg);
    int t = 0;
    while (!valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk({tg, " request seen (R8)"}, 32'(valid), 32'd1);
    chk({tg, "/R5 addr"}, addr, ea);
    chk({tg, "/R4 len"}, 32'(len), 32'(el));
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk({tg, "/R6 eof0"}, 32'(eof0), 32'(e0));
    chk({tg, "/R6 eof1"}, 32'(eof1), 32'(e1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(valid), 0);
    chk("R1 eof0", 32'(eof0), 0);
    chk("R1 eof1", 32'(eof1), 0);
    chk("R1 underflow", 32'(ufl), 0);
    chk("R1 thresh", 32'(thr), 0);

    // table of scenarios, expected bursts computed from R2..R6
    for (int v = 0; v < NVEC; v++) begin
      vec_t    tv;
      logic    r;
      logic [31:0] a, b, c, rem, bw, l;
      string   tg;
      tv = TBL[v];
      en = 1'b0;
      free = 6'd63;
      repeat (2) @(negedge clk);
      wr(3'd0, ctrl_word(tv.dual, tv.code, 3'd0));   // R13 select codes
      wr(3'd1, tv.b0);
      wr(3'd2, tv.c0);
      wr(3'd3, tv.b1);
      wr(3'd4, tv.c1);
      en = 1'b1;
      tg = tv.dual ? "R3" : "R2";
      r = 1'b0;
      a = tv.b0;
      bw = (tv.code >= 3'd4) ? 32'd16 : (32'd1 << tv.code);
      for (int k = 0; k < 8; k++) begin
        c = r ? tv.c1 : tv.c0;
        rem = (c - a + 1) >> 2;
        l = (rem <= bw) ? rem : bw;
        take_burst(a, l[4:0], (rem <= bw) && !r, (rem <= bw) && r, tg);
        if (rem <= bw) begin
          r = tv.dual ? ~r : 1'b0;
          b = r ? tv.b1 : tv.b0;
          a = b;
        end else begin
          a = a + l * 4;
        end
      end
    end

    // R11 threshold field
    en = 1'b0;
    repeat (2) @(negedge clk);
    wr(3'd0, ctrl_word(1'b0, 3'd2, 3'd5));
    chk("R11 thresh", 32'(thr), 32'd5);
    wr(3'd1, 32'h0000_1000);
    wr(3'd2, 32'h0000_1027);

    // R8 gating: disabled, then one word short
    free = 6'd63;
    repeat (4) @(negedge clk);
    chk("R8 no request while disabled", 32'(valid), 0);
    free = 6'd3;
    en = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 no request with free<burst", 32'(valid), 0);
    free = 6'd4;
    take_burst(32'h1000, 5'd4, 1'b0, 1'b0, "R8");

    // R9 hold until ack
    free = 6'd63;
    while (!valid) @(negedge clk);
    repeat (4) begin
      @(negedge clk);
      chk("R9 valid held", 32'(valid), 1);
      chk("R9 addr held", addr, 32'h1010);
      chk("R9 len held", 32'(len), 4);
    end
    take_burst(32'h1010, 5'd4, 1'b0, 1'b0, "R9");

    // R7 shadowed bounds
    wr(3'd1, 32'h0000_5000);
    wr(3'd2, 32'h0000_5007);
    take_burst(32'h1020, 5'd2, 1'b1, 1'b0, "R7");
    take_burst(32'h5000, 5'd2, 1'b1, 1'b0, "R7");
    take_burst(32'h5000, 5'd2, 1'b1, 1'b0, "R7");

    // R12 withdraw and restart at base 0
    en = 1'b0;
    repeat (2) @(negedge clk);
    wr(3'd0, ctrl_word(1'b0, 3'd0, 3'd0));
    wr(3'd2, 32'h0000_500F);
    en = 1'b1;
    take_burst(32'h5000, 5'd1, 1'b0, 1'b0, "R12");
    while (!valid) @(negedge clk);
    chk("R12 next addr", addr, 32'h5004);
    en = 1'b0;
    @(negedge clk);
    chk("R12 request withdrawn", 32'(valid), 0);
    repeat (2) @(negedge clk);
    chk("R12 stays idle", 32'(valid), 0);
    en = 1'b1;
    take_burst(32'h5000, 5'd1, 1'b0, 1'b0, "R12");

    // R10 underflow edge while active, none while disabled
    free = 6'd0;
    repeat (3) @(negedge clk);
    empty = 1'b1;
    @(negedge clk);
    chk("R10 underflow pulse", 32'(ufl), 1);
    @(negedge clk);
    chk("R10 single pulse", 32'(ufl), 0);
    empty = 1'b0;
    en = 1'b0;
    repeat (3) @(negedge clk);
    empty = 1'b1;
    @(negedge clk);
    chk("R10 none while disabled", 32'(ufl), 0);
    @(negedge clk);
    chk("R10 none while disabled (2)", 32'(ufl), 0);
    empty = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule